// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with one control/status byte and one data byte behind a small register interface. Each frame carries eight data bits, or nine when the extended word size is chosen. Bit timing comes from an external baud tick; a doubling control selects whether every tick or every second tick drives the port. On transmit, the ninth bit comes from a control bit that software sets before it writes the data byte. On receive, the ninth bit is captured into a status bit. In 8-bit mode that status bit holds the stop bit instead.

The receiver oversamples each bit sixteen times and decides each bit by a two-of-three vote taken at mid-bit. It drops false starts. It can also filter frames for multiprocessor addressing, so a node only sees address frames until software turns the filter off. Both completion flags stay set until software clears them, and the interrupt output is raised while either flag is set.

Top module: `ser9_port`

## Requirements
- R1: A write to the data byte (addr=1) while the transmitter is idle sends a frame on txd. The frame is a low start bit, eight data bits LSB first, then the ninth bit equal to control bit 3 (in 9-bit mode only), then a high stop bit. Each bit lasts 16 sample enables. A data write while a frame is still going is ignored. txd idles high.
- R2: In 9-bit mode (control bit 7 = 0), an accepted frame stores its ninth bit in control bit 2.
- R3: In 8-bit mode (control bit 7 = 1) with control bit 5 = 0, an accepted frame stores its stop bit in control bit 2.
- R4: The transmit flag (control bit 1) is set when the stop bit of a sent frame ends. A control write with bit 1 = 0 clears it. Writing 1 to that bit has no effect. If a set and a clear arrive in the same cycle, the flag ends up set.
- R5: The receive flag (control bit 0) is set when a frame is accepted, and the data byte then reads as the received byte. A control write with bit 0 = 0 clears it, writing 1 has no effect, and a hardware set wins over a same-cycle clear.
- R6: When control bit 4 (receive enable) is 0, a frame on rxd changes neither the receive flag, control bit 2, nor the data byte.
- R7: With control bit 5 = 1, a 9-bit frame is accepted only if its ninth bit is 1, and an 8-bit frame only if its stop bit is 1. A rejected frame leaves the receive flag, control bit 2 and the data byte unchanged.
- R8: With control bit 6 = 1 every baud tick is a sample enable. With bit 6 = 0 only every second tick is, so one bit lasts 16 or 32 ticks.
- R9: Each received bit is the majority of samples 7, 8 and 9 after the bit edge. So a glitch on rxd shorter than one sample period does not corrupt a bit, and a low pulse that has ended by mid-bit is dropped as a false start.
- R10: irq is high exactly when the transmit flag or the receive flag is set.
- R11: After reset the control byte reads 0x00, the data byte reads 0x00, txd is high and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud tick pulse from an external rate generator |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the control byte, 1 the data byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the register that addr selects |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The hardware setting a completion flag and a software write that clears the same flag can land in the same cycle. The bench provokes this on the transmit flag with the doubled rate, so the frame length in cycles is fixed against the bench's own tick counter. A calibration frame first measures the cycle in which irq rises. An identical frame then places a clearing control write exactly in the setting cycle. The flag must survive that write, and a clear one cycle later must drop it.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  localparam int DW = 8;

  // two-of-three decision for the receiver
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // number of bit slots on the line, start and stop included
  function automatic logic [3:0] frame_len(input logic mode8);
    return mode8 ? 4'd10 : 4'd11;
  endfunction

  // a received frame passes the address filter when the filter is off
  // or when its last payload bit (ninth bit or stop bit) is high
  function automatic logic rx_take(input logic filt_on, input logic last_bit);
    return !filt_on || last_bit;
  endfunction
endpackage

// File: rtl/ser9_sample_gen.sv
module ser9_sample_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic dbl,
  output logic s16
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (baud_tick) phase_q <= ~phase_q;
  end

  assign s16 = baud_tick & (dbl | phase_q);
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
  import ser9_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s16,
  input  logic          start,
  input  logic          mode8,
  input  logic          bit9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LASTC = CW'(OSR - 1);

  logic [DW+2:0] sh_q;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sh_q   <= {1'b1, (mode8 ? 1'b1 : bit9), data, 1'b0};
          left_q <= frame_len(mode8);
          cnt_q  <= '0;
          busy   <= 1'b1;
        end
      end else if (s16) begin
        if (cnt_q == LASTC) begin
          cnt_q  <= '0;
          sh_q   <= {1'b1, sh_q[DW+2:1]};
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/ser9_rx.sv
module ser9_rx
  import ser9_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s16,
  input  logic          en,
  input  logic          mode8,
  input  logic          rxd,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] data,
  output logic          bit8
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LASTC = CW'(OSR - 1);
  localparam logic [CW-1:0] S_A   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OSR / 2);
  localparam logic [CW-1:0] S_C   = CW'(OSR / 2 + 1);

  logic [SYNC-1:0] sy_q;
  logic            rx_s;
  logic [CW-1:0]   cnt_q;
  logic [3:0]      idx_q;
  logic            sa_q, sb_q, stop_q;
  logic [DW:0]     pl_q;
  logic            vote;
  logic [3:0]      stop_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '1;
    else        sy_q <= {sy_q[SYNC-2:0], rxd};
  end

  assign rx_s     = sy_q[SYNC-1];
  assign vote     = maj3(sa_q, sb_q, rx_s);
  assign stop_idx = frame_len(mode8) - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sa_q   <= 1'b1;
      sb_q   <= 1'b1;
      stop_q <= 1'b1;
      pl_q   <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (en && s16 && !rx_s) begin
          busy  <= 1'b1;
          cnt_q <= CW'(1);
          idx_q <= '0;
        end
      end else if (!en) begin
        busy <= 1'b0;
      end else if (s16) begin
        cnt_q <= (cnt_q == LASTC) ? '0 : cnt_q + 1'b1;
        if (cnt_q == S_A) sa_q <= rx_s;
        if (cnt_q == S_B) sb_q <= rx_s;
        if (cnt_q == S_C) begin
          if (idx_q == 4'd0) begin
            if (vote) busy <= 1'b0;      // false start
            else      idx_q <= 4'd1;
          end else if (idx_q == stop_idx) begin
            stop_q <= vote;
            fin    <= 1'b1;
            busy   <= 1'b0;
          end else begin
            pl_q  <= {vote, pl_q[DW:1]};
            idx_q <= idx_q + 4'd1;
          end
        end
      end
    end
  end

  assign data = mode8 ? pl_q[DW:1] : pl_q[DW-1:0];
  assign bit8 = mode8 ? stop_q : pl_q[DW];
endmodule

// File: rtl/ser9_port.sv
module ser9_port
  import ser9_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rxd,
  output logic          txd,
  output logic          irq
);
  logic mode8_q, dbl_q, mpe_q, ren_q, tx9_q, rb8_q, ti_q, ri_q;
  logic [DW-1:0] rbuf_q;

  logic          s16;
  logic          ctl_wr, dat_wr;
  logic          tx_busy, tx_done;
  logic          rx_busy, rx_fin, rx_bit8, rx_load;
  logic [DW-1:0] rx_data;

  assign ctl_wr = wr_en & ~addr;
  assign dat_wr = wr_en & addr;

  ser9_sample_gen u_gen (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .dbl(dbl_q), .s16(s16)
  );

  ser9_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .s16(s16), .start(dat_wr), .mode8(mode8_q),
    .bit9(tx9_q), .data(wr_data), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  ser9_rx #(.OSR(OSR), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .s16(s16), .en(ren_q), .mode8(mode8_q),
    .rxd(rxd), .busy(rx_busy), .fin(rx_fin), .data(rx_data), .bit8(rx_bit8)
  );

  assign rx_load = rx_fin & rx_take(mpe_q, rx_bit8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode8_q <= 1'b0;
      dbl_q   <= 1'b0;
      mpe_q   <= 1'b0;
      ren_q   <= 1'b0;
      tx9_q   <= 1'b0;
      rb8_q   <= 1'b0;
      ti_q    <= 1'b0;
      ri_q    <= 1'b0;
      rbuf_q  <= '0;
    end else begin
      if (ctl_wr) begin
        mode8_q <= wr_data[7];
        dbl_q   <= wr_data[6];
        mpe_q   <= wr_data[5];
        ren_q   <= wr_data[4];
        tx9_q   <= wr_data[3];
      end
      if (rx_load)     rb8_q <= rx_bit8;
      else if (ctl_wr) rb8_q <= wr_data[2];
      if (tx_done)                     ti_q <= 1'b1;
      else if (ctl_wr && !wr_data[1])  ti_q <= 1'b0;
      if (rx_load)                     ri_q <= 1'b1;
      else if (ctl_wr && !wr_data[0])  ri_q <= 1'b0;
      if (rx_load) rbuf_q <= rx_data;
    end
  end

  assign rd_data = addr ? rbuf_q
                        : {mode8_q, dbl_q, mpe_q, ren_q, tx9_q, rb8_q, ti_q, ri_q};
  assign irq = ti_q | ri_q;
endmodule

// File: rtl/ser9_port_chk.sv
module ser9_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       rx_fin,
  input logic       rx_load,
  input logic       rx_busy,
  input logic       rx_bit8,
  input logic       s16,
  input logic       dbl,
  input logic       mode8,
  input logic       mpe,
  input logic       ren,
  input logic       ti,
  input logic       ri
);
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R1
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd); // R1
  AST_TI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> ti); // R4
  AST_TI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !(wr_en && !addr && !wr_data[1])) |=> ti); // R4
  AST_RI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> ri); // R5
  AST_RI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !(wr_en && !addr && !wr_data[0])) |=> ri); // R5
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !rx_busy); // R6
  AST_MP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && mpe && !mode8 && !rx_bit8 && !ri) |=> !ri); // R7
  AST_SAMPLE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (s16 && !dbl) |=> (!s16 || dbl)); // R8
endmodule

bind ser9_port ser9_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done), .rx_fin(rx_fin),
  .rx_load(rx_load), .rx_busy(rx_busy), .rx_bit8(rx_bit8), .s16(s16),
  .dbl(dbl_q), .mode8(mode8_q), .mpe(mpe_q), .ren(ren_q), .ti(ti_q), .ri(ri_q)
);

// File: tb/ser9_port_tb_top.sv
module ser9_port_tb_top;
  localparam int HALF = 2; // 4 ns period, 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [1:0] bcnt = 2'd0;

  ser9_port dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd),
    .txd(txd), .irq(irq)
  );

  always #HALF clk = ~clk;

  // baud tick: one cycle high out of every four
  always @(negedge clk) begin
    bcnt      <= bcnt + 2'd1;
    baud_tick <= (bcnt == 2'd3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    @(negedge clk); #1;
    addr = a;
    #1 d = rd_data;
  endtask

  // control byte: word size, doubling, filter, enable, tx ninth, rx ninth, flags
  function automatic logic [7:0] ctl(input logic m8, input logic dbl, input logic mp,
                                     input logic ren, input logic t9, input logic r8,
                                     input logic keep_ti, input logic keep_ri);
    return {m8, dbl, mp, ren, t9, r8, keep_ti, keep_ri};
  endfunction

  function automatic int bit_cycles(input logic dbl);
    return dbl ? 16 * 4 : 16 * 8;
  endfunction

  function automatic logic [10:0] tx_expect(input logic m8, input logic t9, input logic [7:0] d);
    logic [10:0] f;
    f = 11'h7FF;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (!m8) f[9] = t9;
    return f;
  endfunction

  // acceptance per the filter rule, written from the requirement
  function automatic logic rx_expect_take(input logic m8, input logic mp,
                                          input logic ninth, input logic stop);
    if (!mp) return 1'b1;
    if (m8)  return stop;
    return ninth;
  endfunction

  task automatic drive_bit(input logic v, input int b, input logic glitch);
    rxd = v;
    if (glitch) begin
      step(b / 2 - 2);
      rxd = ~v;
      step(4);
      rxd = v;
      step(b / 2 - 2);
    end else begin
      step(b);
    end
  endtask

  task automatic send_frame(input logic m8, input logic dbl, input logic ninth,
                            input logic stop, input logic [7:0] d, input int gbit);
    int b;
    b = bit_cycles(dbl);
    drive_bit(1'b0, b, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], b, gbit == i);
    if (!m8) drive_bit(ninth, b, 1'b0);
    drive_bit(stop, b, 1'b0);
    rxd = 1'b1;
    step(2 * b);
  endtask

  // capture a transmitted frame; optionally issue a second data write mid-frame
  task automatic tx_run(input logic m8, input logic dbl, input logic t9, input logic [7:0] d,
                        input logic dup, output logic [10:0] cap, output int width);
    int b, nb, r, f;
    logic prev;
    b = bit_cycles(dbl);
    nb = m8 ? 10 : 11;
    cap = 11'h7FF;
    r = -1; f = -1;
    reg_wr(1'b0, ctl(m8, dbl, 1'b0, 1'b0, t9, 1'b0, 1'b0, 1'b1));
    reg_wr(1'b1, d);
    prev = txd;
    for (int c = 0; c < nb * b + 64; c++) begin
      for (int i = 0; i < nb; i++)
        if (c == i * b + b / 2 - 4) cap[i] = txd;
      if (txd && !prev && r < 0) r = c;
      if (!txd && prev && r >= 0 && f < 0) f = c;
      prev = txd;
      if (dup && c == 3) begin addr = 1'b1; wr_data = ~d; wr_en = 1'b1; end
      @(negedge clk); #1;
      wr_en = 1'b0;
    end
    width = (r >= 0 && f >= 0) ? f - r : -1;
  endtask

  // data write aligned to the tick counter; optional clear write at cycle clr_at
  task automatic tx_timed(input int clr_at, output int rise_k, output logic irq_after);
    rise_k = -1;
    irq_after = 1'b0;
    do begin @(negedge clk); #1; end while (bcnt != 2'd0);
    addr = 1'b1; wr_data = 8'h3C; wr_en = 1'b1;
    for (int k = 1; k < 3000; k++) begin
      @(negedge clk); #1;
      wr_en = 1'b0;
      if (rise_k >= 0) begin irq_after = irq; break; end
      if (irq && rise_k < 0) begin
        rise_k = k;
        if (clr_at < 0) break;
      end
      if (k == clr_at) begin
        addr = 1'b0; wr_data = ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); wr_en = 1'b1;
      end
    end
  endtask

  initial begin
    logic [7:0] rv, rbuf_exp, dv;
    logic [10:0] cap;
    int w, t_cal, t_hit;
    logic m8, dbl, mp, ninth, stop, p, take, ia;
    logic [31:0] seed;

    seed = $urandom(32'd2718);
    rbuf_exp = 8'h00;
    step(5);
    rst_n = 1'b1;
    step(3);

    // R11 reset state
    reg_rd(1'b0, rv); chk("R11 ctrl after reset", rv, 8'h00);
    reg_rd(1'b1, rv); chk("R11 data after reset", rv, 8'h00);
    chk("R11 txd idle", txd, 1'b1);
    chk("R11 irq low", irq, 1'b0);

    // R1 / R8 directed frames with bit width measured on the line
    tx_run(1'b1, 1'b0, 1'b0, 8'h55, 1'b0, cap, w);
    chk("R1 8-bit frame", cap, tx_expect(1'b1, 1'b0, 8'h55));
    chk("R8 bit width single rate", w, 128);
    reg_rd(1'b0, rv); chk("R4 ti after frame", rv[1], 1'b1);
    chk("R10 irq with ti", irq, 1'b1);
    reg_wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    reg_rd(1'b0, rv); chk("R4 writing one keeps ti", rv[1], 1'b1);
    reg_wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    reg_rd(1'b0, rv); chk("R4 ti cleared", rv[1], 1'b0);
    chk("R10 irq low after clear", irq, 1'b0);

    tx_run(1'b0, 1'b1, 1'b1, 8'h55, 1'b0, cap, w);
    chk("R1 9-bit frame ninth=1", cap, tx_expect(1'b0, 1'b1, 8'h55));
    chk("R8 bit width doubled", w, 64);

    tx_run(1'b0, 1'b0, 1'b0, 8'hC3, 1'b1, cap, w);
    chk("R1 write while busy ignored", cap, tx_expect(1'b0, 1'b0, 8'hC3));

    // R1 random frames
    for (int n = 0; n < 5; n++) begin
      m8 = 1'($urandom); dbl = 1'($urandom); p = 1'($urandom); dv = 8'($urandom);
      tx_run(m8, dbl, p, dv, 1'b0, cap, w);
      chk("R1 random tx frame", cap, tx_expect(m8, p, dv));
      reg_rd(1'b0, rv); chk("R4 ti random tx", rv[1], 1'b1);
    end

    // R4 same-cycle set and clear: calibrate, then collide
    reg_wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    tx_timed(-1, t_cal, ia);
    reg_wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    tx_timed(t_cal - 1, t_hit, ia);
    chk("R4 set cycle repeatable", t_hit, t_cal);
    chk("R4 set wins over same-cycle clear", ia, 1'b1);
    reg_wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R4 later clear drops ti", irq, 1'b0);

    // R6 receiver disabled
    reg_wr(1'b0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    send_frame(1'b0, 1'b0, 1'b1, 1'b1, 8'hA7, -1);
    reg_rd(1'b0, rv);
    chk("R6 ri unchanged when disabled", rv[0], 1'b0);
    chk("R6 rx ninth unchanged when disabled", rv[2], 1'b0);
    reg_rd(1'b1, rv); chk("R6 data unchanged when disabled", rv, rbuf_exp);

    // R9 false start then a glitched but valid frame
    reg_wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    rxd = 1'b0; step(24); rxd = 1'b1; step(400);
    reg_rd(1'b0, rv); chk("R9 false start dropped", rv[0], 1'b0);
    send_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h96, 3);
    rbuf_exp = 8'h96;
    reg_rd(1'b1, rv); chk("R9 glitch outvoted", rv, 8'h96);
    reg_rd(1'b0, rv); chk("R5 ri set on frame", rv[0], 1'b1);
    chk("R3 stop bit captured", rv[2], 1'b1);
    chk("R10 irq with ri", irq, 1'b1);

    // R7 directed: 9-bit filtered frame with ninth=0 rejected, ninth=1 accepted
    reg_wr(1'b0, ctl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    send_frame(1'b0, 1'b0, 1'b0, 1'b1, 8'h11, -1);
    reg_rd(1'b0, rv); chk("R7 data frame filtered", rv[0], 1'b0);
    reg_rd(1'b1, rv); chk("R7 buffer kept", rv, rbuf_exp);
    send_frame(1'b0, 1'b0, 1'b1, 1'b1, 8'h42, -1);
    rbuf_exp = 8'h42;
    reg_rd(1'b1, rv); chk("R7 address frame taken", rv, 8'h42);
    reg_rd(1'b0, rv); chk("R2 ninth bit captured", rv[2], 1'b1);

    // R2 R3 R5 R7 random receptions against the bench model
    for (int n = 0; n < 12; n++) begin
      m8 = 1'($urandom); dbl = 1'($urandom); mp = 1'($urandom);
      ninth = 1'($urandom); p = 1'($urandom); dv = 8'($urandom);
      stop = m8 ? (($urandom % 4) != 0) : 1'b1;
      reg_wr(1'b0, ctl(m8, dbl, mp, 1'b1, 1'b0, p, 1'b0, 1'b0));
      send_frame(m8, dbl, ninth, stop, dv, -1);
      take = rx_expect_take(m8, mp, ninth, stop);
      if (take) rbuf_exp = dv;
      reg_rd(1'b0, rv);
      chk("R5 R7 ri after random frame", rv[0], take);
      if (m8) chk("R3 rx status bit", rv[2], take ? stop : p);
      else    chk("R2 rx status bit", rv[2], take ? ninth : p);
      chk("R10 irq follows ri", irq, take);
      reg_rd(1'b1, rv); chk("R5 data byte", rv, rbuf_exp);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule